// File: doc/BRIEF.md
# Dual-Buffer Serial Flash Slave Front-End

This block is the serial-port side of a page-organised flash device. It is a synchronous slave that oversamples the chip-select, serial clock and serial data lines with the system clock. It decodes a one-byte command and, when the command has an address, a three-byte address. It then serves the commands that never touch the flash array: it reads from or writes to either of two 264-byte on-chip buffers, and it streams a status byte. Commands that need the array are not executed here. The block captures their opcode and page number and gives the array engine a single-cycle start strobe when chip-select is released.

A host can drive the port in SPI mode 0 or mode 3. Incoming bits are taken on rising serial-clock edges, most significant bit first. Outgoing bits change on falling edges, so the host samples them on the next rising edge. Byte pointers inside a buffer run from 0 to 263 and then return to 0. While the array engine is busy, it reports which buffer it owns. Commands that target that buffer, and any further array command, are dropped, but the other buffer stays fully usable.

The control state machine has these states:
- IDLE: chip-select is high.
- OPCODE: the eight command bits.
- ADDR: the 24 address bits.
- DUMMY: the eight padding bits of a buffer read.
- RDDATA: buffer data out.
- WRDATA: buffer data in.
- STATUS: status bytes out.
- ARRAY: an array command is complete and waits for chip-select to rise.
- IGNORE: the command is unknown or blocked.

The transitions are:
- Any state goes to IDLE when chip-select is high.
- A falling chip-select enters OPCODE.
- At the end of OPCODE the machine goes to STATUS, ADDR or IGNORE.
- At the end of ADDR it goes to DUMMY, WRDATA or ARRAY.
- At the end of DUMMY it goes to RDDATA.

Top module: `dbuf_flash_front`

## Requirements
- R1: A command starts when chip-select falls. SI is sampled on each rising SCK edge, MSB first: 8 opcode bits, then (for addressed commands) 24 address bits. This works with SCK idle low (mode 0) or idle high (mode 3) when chip-select falls.
- R2: Opcode 0x57 outputs the status byte, MSB first. Bit 7 is 1 when the array is not busy. Bit 6 is the compare-miss input. Bits 5..3 are 1,0,0. Bits 2..0 are 0. With not busy and compare-miss=1, the byte is 0xE0.
- R3: While chip-select stays low, the status byte repeats. Each repeat takes fresh input values, so asserting busy between bytes gives 0x60 on the next byte (compare-miss=1).
- R4: Opcodes 0x84 (buffer 0) and 0x87 (buffer 1) take an address whose low 9 bits are the start byte; the upper 15 bits are ignored. Every complete following byte is stored at successive positions. A partial byte at chip-select rise is discarded.
- R5: Opcodes 0x54 (buffer 0) and 0x56 (buffer 1) take the same address layout, then 8 ignored bits. After that, SO presents buffer bytes MSB first from the start byte, changing on falling SCK edges.
- R6: During buffer reads and writes, the byte after position 263 is position 0.
- R7: When chip-select is high, spi_so_en is 0, and any read in progress ends.
- R8: While arr_busy is 1, commands to the buffer named by arr_buf_sel (0 = buffer 0) have no effect: no write, and spi_so_en stays 0. The other buffer reads and writes normally.
- R9: Array opcodes 0x52, 0x53, 0x55, 0x58, 0x59, 0x60, 0x61, 0x82, 0x83, 0x85, 0x86, 0x88, 0x89 take the page number from address bits 20..9. After all 24 address bits, a chip-select rise gives exactly one arr_start cycle with arr_opcode and arr_page valid. There is no strobe if the address is incomplete or if arr_busy was 1 at decode.
- R10: Any other opcode is ignored: no write, no strobe, and spi_so_en stays 0 until chip-select falls again.
- R11: A start address from 264 to 511 selects position (address - 264).
- R12: After reset, spi_so_en and arr_start are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_en | output | 1 | Output enable for spi_so |
| arr_busy | input | 1 | Array engine busy |
| arr_buf_sel | input | 1 | Buffer owned by the busy array engine |
| arr_cmp_miss | input | 1 | Last page-compare result, reported in status bit 6 |
| arr_start | output | 1 | One-cycle start strobe for an array command |
| arr_opcode | output | 8 | Opcode of the latest accepted array command |
| arr_page | output | 12 | Page number of the latest accepted array command |

## Verification
Both buffers are filled end to end with an arithmetic pattern in mode 0 and read back in mode 3. This separates the two banks and confirms that the bit order and edge choice are the same in both clock polarities. Shorter transfers then start close to position 263 and above 263, which separates correct modulo-264 wrapping from power-of-two wrapping. Status reads with busy toggled mid-command show whether the byte is refreshed on each repeat. Partial bytes, unknown opcodes, truncated array commands and busy-blocked commands are each followed by a read-back or a strobe count, which shows they left no trace.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

    localparam logic [7:0] OP_STAT  = 8'h57;
    localparam logic [7:0] OP_RD_B0 = 8'h54;
    localparam logic [7:0] OP_RD_B1 = 8'h56;
    localparam logic [7:0] OP_WR_B0 = 8'h84;
    localparam logic [7:0] OP_WR_B1 = 8'h87;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPCODE, ST_ADDR, ST_DUMMY, ST_RDDATA,
        ST_WRDATA, ST_STATUS, ST_ARRAY, ST_IGNORE
    } fe_state_e;

    typedef enum logic [2:0] {
        K_NONE, K_STAT, K_BRD, K_BWR, K_ARR
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e kind;
        logic      sel;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_op(input logic [7:0] op);
        cmd_dec_t d;
        d.kind = K_NONE;
        d.sel  = 1'b0;
        case (op)
            OP_STAT:  d.kind = K_STAT;
            OP_RD_B0: d.kind = K_BRD;
            OP_RD_B1: begin d.kind = K_BRD; d.sel = 1'b1; end
            OP_WR_B0: d.kind = K_BWR;
            OP_WR_B1: begin d.kind = K_BWR; d.sel = 1'b1; end
            8'h52, 8'h53, 8'h55, 8'h58, 8'h59, 8'h60, 8'h61,
            8'h82, 8'h83, 8'h85, 8'h86, 8'h88, 8'h89: d.kind = K_ARR;
            default: d.kind = K_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dbf_edge.sv
module dbf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise
);
    logic sck_d;
    logic cs_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck;
            cs_d  <= cs_n;
        end
    end

    assign sck_rise = sck & ~sck_d;
    assign sck_fall = ~sck & sck_d;
    assign cs_fall  = ~cs_n & cs_d;
    assign cs_rise  = cs_n & ~cs_d;

endmodule

// File: rtl/dbf_buffers.sv
module dbf_buffers #(
    parameter int NBUF   = 2,
    parameter int DEPTH  = 264,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic [7:0] bank_rd [NBUF];

    for (genvar b = 0; b < NBUF; b++) begin : g_bank
        logic [7:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == 1'(b)))
                mem[wr_addr] <= wr_data;
        end
        assign bank_rd[b] = mem[rd_addr];
    end

    assign rd_data = bank_rd[rd_sel];

    // R6: a write never lands past the last buffer position
    assert_wr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < DEPTH));

    // R6: reads stay inside the buffer as well
    assert_rd_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_addr) < DEPTH);

endmodule

// File: rtl/dbf_tx.sv
module dbf_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       shift_en,
    input  logic [7:0] byte_in,
    output logic       load,
    output logic       so,
    output logic       so_en_q
);
    logic [6:0] tx_q;
    logic [2:0] left_q;

    assign load = shift_en && (left_q == 3'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q    <= '0;
            left_q  <= '0;
            so      <= 1'b0;
            so_en_q <= 1'b0;
        end else if (clear) begin
            left_q  <= '0;
            so_en_q <= 1'b0;
        end else if (load) begin
            so      <= byte_in[7];
            tx_q    <= byte_in[6:0];
            left_q  <= 3'd7;
            so_en_q <= 1'b1;
        end else if (shift_en) begin
            so      <= tx_q[6];
            tx_q    <= {tx_q[5:0], 1'b0};
            left_q  <= left_q - 3'd1;
        end
    end

    // R7: the enable is released within one clock of chip-select going high
    assert_en_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !so_en_q);

endmodule

// File: rtl/dbuf_flash_front.sv
module dbuf_flash_front
    import dbf_pkg::*;
#(
    parameter int BUF_BYTES = 264,
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 12,
    parameter int ADDR_BITS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_en,
    input  logic              arr_busy,
    input  logic              arr_buf_sel,
    input  logic              arr_cmp_miss,
    output logic              arr_start,
    output logic [7:0]        arr_opcode,
    output logic [PAGE_W-1:0] arr_page
);
    localparam int                KEEP_W    = PAGE_W + ADDR_W;
    localparam logic [4:0]        ADDR_LAST = 5'(ADDR_BITS - 1);
    localparam logic [ADDR_W-1:0] DEPTH_V   = ADDR_W'(BUF_BYTES);
    localparam logic [ADDR_W-1:0] LAST_V    = ADDR_W'(BUF_BYTES - 1);
    localparam logic [2:0]        DENSITY   = 3'b100;

    fe_state_e state_q, state_d;

    logic              sck_rise, sck_fall, cs_fall, cs_rise;
    logic [6:0]        sh_q;
    logic [7:0]        si_byte;
    logic [KEEP_W-2:0] addr_q;
    logic [KEEP_W-1:0] addr_next;
    logic [4:0]        cnt_q;
    cmd_kind_e         kind_q;
    logic              sel_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [7:0]        op_q;
    cmd_dec_t          dec;
    logic              blocked;
    logic              opc_done, addr_done;
    logic              wr_en;
    logic [7:0]        rd_data, tx_byte, status_byte;
    logic              shift_en, tx_load, so_en_q;

    function automatic logic [ADDR_W-1:0] ptr_inc(input logic [ADDR_W-1:0] p);
        return (p == LAST_V) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [ADDR_W-1:0] ptr_norm(input logic [ADDR_W-1:0] a);
        return (a >= DEPTH_V) ? a - DEPTH_V : a;
    endfunction

    dbf_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise)
    );

    assign si_byte   = {sh_q, spi_si};
    assign addr_next = {addr_q, spi_si};
    assign dec       = decode_op(si_byte);
    assign blocked   = arr_busy &&
                       ((dec.kind == K_ARR) ||
                        (((dec.kind == K_BRD) || (dec.kind == K_BWR)) &&
                         (dec.sel == arr_buf_sel)));

    assign opc_done  = !spi_cs_n && !cs_fall && sck_rise &&
                       (state_q == ST_OPCODE) && (cnt_q == 5'd7);
    assign addr_done = !spi_cs_n && !cs_fall && sck_rise &&
                       (state_q == ST_ADDR) && (cnt_q == ADDR_LAST);
    assign wr_en     = !spi_cs_n && sck_rise &&
                       (state_q == ST_WRDATA) && (cnt_q == 5'd7);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (spi_cs_n) begin
            state_d = ST_IDLE;
        end else if (cs_fall) begin
            state_d = ST_OPCODE;
        end else if (sck_rise) begin
            unique case (state_q)
                ST_OPCODE: begin
                    if (cnt_q == 5'd7) begin
                        if ((dec.kind == K_NONE) || blocked) state_d = ST_IGNORE;
                        else if (dec.kind == K_STAT)         state_d = ST_STATUS;
                        else                                 state_d = ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (cnt_q == ADDR_LAST) begin
                        if (kind_q == K_BRD)      state_d = ST_DUMMY;
                        else if (kind_q == K_BWR) state_d = ST_WRDATA;
                        else                      state_d = ST_ARRAY;
                    end
                end
                ST_DUMMY: if (cnt_q == 5'd7) state_d = ST_RDDATA;
                ST_IDLE, ST_RDDATA, ST_WRDATA, ST_STATUS,
                ST_ARRAY, ST_IGNORE: state_d = state_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            sh_q       <= '0;
            addr_q     <= '0;
            kind_q     <= K_NONE;
            sel_q      <= 1'b0;
            op_q       <= '0;
            ptr_q      <= '0;
            arr_start  <= 1'b0;
            arr_opcode <= '0;
            arr_page   <= '0;
        end else begin
            arr_start <= cs_rise && (state_q == ST_ARRAY);
            if (state_d != state_q)
                cnt_q <= '0;
            else if (sck_rise && !spi_cs_n)
                cnt_q <= ((state_q == ST_WRDATA) && (cnt_q == 5'd7)) ? '0 : cnt_q + 5'd1;
            if (sck_rise && !spi_cs_n) begin
                sh_q   <= si_byte[6:0];
                addr_q <= addr_next[KEEP_W-2:0];
            end
            if (opc_done) begin
                kind_q <= dec.kind;
                sel_q  <= dec.sel;
                op_q   <= si_byte;
            end
            if (addr_done) begin
                ptr_q <= ptr_norm(addr_next[ADDR_W-1:0]);
                if (kind_q == K_ARR) begin
                    arr_opcode <= op_q;
                    arr_page   <= addr_next[KEEP_W-1:ADDR_W];
                end
            end else if (wr_en || (tx_load && (state_q == ST_RDDATA))) begin
                ptr_q <= ptr_inc(ptr_q);
            end
        end
    end

    dbf_buffers #(
        .NBUF   (2),
        .DEPTH  (BUF_BYTES),
        .ADDR_W (ADDR_W)
    ) u_bufs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (sel_q),
        .wr_addr (ptr_q),
        .wr_data (si_byte),
        .rd_sel  (sel_q),
        .rd_addr (ptr_q),
        .rd_data (rd_data)
    );

    assign status_byte = {~arr_busy, arr_cmp_miss, DENSITY, 3'b000};
    assign tx_byte     = (state_q == ST_STATUS) ? status_byte : rd_data;
    assign shift_en    = sck_fall && !spi_cs_n &&
                         ((state_q == ST_RDDATA) || (state_q == ST_STATUS));

    dbf_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (spi_cs_n),
        .shift_en (shift_en),
        .byte_in  (tx_byte),
        .load     (tx_load),
        .so       (spi_so),
        .so_en_q  (so_en_q)
    );

    assign spi_so_en = so_en_q && !spi_cs_n;

    // R7: releasing chip-select returns the controller to idle
    assert_cs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> (state_q == ST_IDLE));

    // R9: the start strobe lasts a single cycle
    assert_start_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |=> !arr_start);

    // R9: a strobe only follows a fully addressed array command
    assert_start_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |-> ($past(state_q) == ST_ARRAY));

    // R10: the output is only enabled in the two data-out states
    assert_en_states_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_so_en |-> ((state_q == ST_RDDATA) || (state_q == ST_STATUS)));

    // R4: buffer writes happen only in the data-in state of a write command
    assert_wr_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (kind_q == K_BWR));

endmodule

// File: tb/dbuf_flash_front_tb.sv
module dbuf_flash_front_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic so, so_en;
    logic busy = 1'b0, bsel = 1'b0, cmp = 1'b0;
    logic start;
    logic [7:0]  aop;
    logic [11:0] apage;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    logic [7:0]  cap_op = '0;
    logic [11:0] cap_page = '0;
    logic mode3 = 1'b0;
    logic en_seen = 1'b0;
    logic done = 1'b0;
    logic [7:0] mdl [2][264];

    always #2 clk = ~clk;

    dbuf_flash_front dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
        .spi_so(so), .spi_so_en(so_en), .arr_busy(busy), .arr_buf_sel(bsel),
        .arr_cmp_miss(cmp), .arr_start(start), .arr_opcode(aop), .arr_page(apage)
    );

    always @(posedge clk) begin
        if (rst_n && start) begin
            pulses   <= pulses + 1;
            cap_op   <= aop;
            cap_page <= apage;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i >= 8 - nb; i--) begin
            @(negedge clk); sck = 1'b0; si = tx[i];
            repeat (2) @(negedge clk);
            rx[i] = so;
            if (so_en) en_seen = 1'b1;
            sck = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic begin_cmd();
        @(negedge clk); sck = mode3;
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
        en_seen = 1'b0;
    endtask

    task automatic end_cmd();
        @(negedge clk); if (!mode3) sck = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    function automatic int norm(input int a);
        return (a >= 264) ? a - 264 : a;
    endfunction

    task automatic send_hdr(input logic [7:0] op, input int addr9);
        logic [7:0] r;
        logic [23:0] a;
        a = {15'h7FFF, 9'(addr9)};
        xfer(op, 8, r);
        xfer(a[23:16], 8, r);
        xfer(a[15:8], 8, r);
        xfer(a[7:0], 8, r);
    endtask

    // write n bytes of pattern; upd=0 when the write is expected to be dropped
    task automatic buf_write(input int b, input int st, input int n, input int seed, input bit upd);
        logic [7:0] r;
        int p;
        begin_cmd();
        send_hdr(b ? 8'h87 : 8'h84, st);
        p = norm(st);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = 8'((i * 37 + seed) & 255);
            xfer(v, 8, r);
            if (upd) mdl[b][p] = v;
            p = (p == 263) ? 0 : p + 1;
        end
        end_cmd();
    endtask

    task automatic buf_read(input int b, input int st, input int n, input string req);
        logic [7:0] r;
        int p;
        begin_cmd();
        send_hdr(b ? 8'h56 : 8'h54, st);
        xfer(8'hFF, 8, r);
        p = norm(st);
        for (int i = 0; i < n; i++) begin
            xfer(8'h00, 8, r);
            chk(req, r, mdl[b][p]);
            p = (p == 263) ? 0 : p + 1;
        end
        end_cmd();
        chk("R7 so_en low after CS high", so_en, 0);
    endtask

    task automatic arr_cmd(input logic [7:0] op, input logic [11:0] pg, input int nbytes);
        logic [7:0] r;
        logic [23:0] a;
        a = {3'b000, pg, 9'h0};
        begin_cmd();
        xfer(op, 8, r);
        if (nbytes > 0) xfer(a[23:16], 8, r);
        if (nbytes > 1) xfer(a[15:8], 8, r);
        if (nbytes > 2) xfer(a[7:0], 8, r);
        end_cmd();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int p0;
        repeat (3) @(negedge clk);
        chk("R12 reset so_en", so_en, 0);
        chk("R12 reset arr_start", start, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 idle so_en", so_en, 0);

        // R2 R3: status, mode 0 and mode 3
        for (int m = 0; m < 2; m++) begin
            mode3 = 1'(m); busy = 1'b0; cmp = 1'b1;
            begin_cmd();
            xfer(8'h57, 8, r);
            xfer(8'h00, 8, r);
            chk("R2 status ready", r, 8'hE0);
            busy = 1'b1;
            xfer(8'h00, 8, r);
            chk("R3 status refreshed busy", r, 8'h60);
            busy = 1'b0; cmp = 1'b0;
            xfer(8'h00, 8, r);
            chk("R3 status refreshed cmp", r, 8'hA0);
            end_cmd();
            chk("R7 so_en after status", so_en, 0);
        end

        // R1 R4 R5: full fill in mode 0, full read in mode 3
        mode3 = 1'b0;
        buf_write(0, 0, 264, 5, 1'b1);
        buf_write(1, 0, 264, 101, 1'b1);
        mode3 = 1'b1;
        buf_read(0, 0, 264, "R5 R1 full read buf0");
        buf_read(1, 0, 264, "R5 R1 full read buf1");

        // R6: wrap at 264 on write and read
        mode3 = 1'b0;
        buf_write(0, 260, 10, 77, 1'b1);
        buf_read(0, 258, 12, "R6 wrap read buf0");
        mode3 = 1'b1;
        buf_write(1, 262, 4, 9, 1'b1);
        buf_read(1, 261, 6, "R6 wrap read buf1");

        // R11: start address above 263
        buf_write(1, 300, 3, 200, 1'b1);
        buf_read(1, 36, 3, "R11 high start address");
        buf_read(0, 511, 2, "R11 start 511");

        // R4: partial byte discarded
        mode3 = 1'b0;
        begin_cmd();
        send_hdr(8'h84, 100);
        xfer(8'hC3, 8, r); mdl[0][100] = 8'hC3;
        xfer(8'h3C, 4, r);
        end_cmd();
        buf_read(0, 99, 3, "R4 partial byte");

        // R10: unknown opcodes
        foreach (p0_list[k]) ;
        for (int k = 0; k < 3; k++) begin
            logic [7:0] op;
            op = (k == 0) ? 8'h00 : ((k == 1) ? 8'hA5 : 8'h57 ^ 8'h80);
            p0 = pulses;
            begin_cmd();
            xfer(op, 8, r);
            for (int j = 0; j < 5; j++) xfer(8'h84, 8, r);
            chk("R10 unknown op no enable", en_seen, 0);
            end_cmd();
            chk("R10 unknown op no strobe", pulses, p0);
        end
        buf_read(0, 0, 8, "R10 buffer untouched");

        // R9: array command
        p0 = pulses;
        arr_cmd(8'h83, 12'hABC, 3);
        @(negedge clk);
        chk("R9 one strobe", pulses, p0 + 1);
        chk("R9 opcode", cap_op, 8'h83);
        chk("R9 page", cap_page, 12'hABC);
        mode3 = 1'b1;
        arr_cmd(8'h53, 12'h005, 3);
        @(negedge clk);
        chk("R9 strobe mode 3", pulses, p0 + 2);
        chk("R9 page mode 3", cap_page, 12'h005);
        arr_cmd(8'h58, 12'h123, 2);
        @(negedge clk);
        chk("R9 truncated no strobe", pulses, p0 + 2);

        // R8: busy blocks the owned buffer only
        busy = 1'b1; bsel = 1'b0;
        buf_write(0, 0, 4, 55, 1'b0);
        begin_cmd();
        send_hdr(8'h54, 0);
        for (int j = 0; j < 3; j++) xfer(8'h00, 8, r);
        chk("R8 blocked read no enable", en_seen, 0);
        end_cmd();
        buf_write(1, 10, 2, 66, 1'b1);
        buf_read(1, 10, 2, "R8 other buffer usable");
        arr_cmd(8'h82, 12'h010, 3);
        @(negedge clk);
        chk("R8 R9 busy no strobe", pulses, p0 + 2);
        busy = 1'b0;
        buf_read(0, 0, 4, "R8 blocked write dropped");
        bsel = 1'b1; busy = 1'b1;
        buf_write(1, 20, 2, 11, 1'b0);
        buf_write(0, 20, 2, 12, 1'b1);
        busy = 1'b0;
        buf_read(1, 20, 2, "R8 blocked buf1 write");
        buf_read(0, 20, 2, "R8 buf0 usable");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    int p0_list [1];

endmodule